// File: doc/BRIEF.md
# USB Full-Speed Byte Transmit Serializer

This block drives a USB full-speed packet onto a differential D+/D- pair one byte at a time. It runs from a system clock much faster than the 12 Mbit/s bus rate. A 16-bit fractional phase accumulator produces a one-cycle bit strobe. All line activity is paced by that strobe, so the bus bit rate stays the same at any system-clock rate.

A writer loads one byte at a time into a single holding register. It watches `ready` before it offers the next byte. Behind the holding register sits one shifter, and there is no deeper queue. The shifter inserts stuffed zero bits, NRZI-encodes the stream and opens every packet with a SYNC byte. The writer marks the final byte of a packet with a last flag, and the block closes the packet with the end-of-packet signal. If the shifter runs dry in the middle of a packet, a sticky underflow flag is set and the packet is cut short with an end-of-packet. CRC bytes and PIDs are plain bytes to this block.

The controller has six named states:
- `ST_IDLE`: the line is released. It goes to `ST_SYNC` on a strobe while the holding register is full.
- `ST_SYNC`: the shifter sends the SYNC byte. It goes to `ST_DATA` on the strobe that loads the first data byte.
- `ST_DATA`: the shifter sends the queued bytes. It goes to `ST_SE0_1` once the last byte is sent, or at once on underflow.
- `ST_SE0_1` then `ST_SE0_2`: two bit times of SE0.
- `ST_EOP_J`: one bit time of J, then back to `ST_IDLE`.

Top module: `fs_tx_serializer`

## Requirements
- R1: After reset the line is idle J with the driver released (`usb_dp`=1, `usb_dm`=0, `usb_oe`=0), `ready`=1 and `underflow`=0. Whenever `usb_oe` is low, the pins show J.
- R2: `bit_tick` is a one-cycle pulse issued on each overflow of a 16-bit accumulator. The accumulator steps by round(12 MHz / f_sys × 65536), which is 15729 at 50 MHz. Any 65536 consecutive cycles therefore hold exactly that many strobes. Successive strobes are spaced either floor(65536/inc) or ceil(65536/inc) cycles apart, which is 4 or 5 at 50 MHz.
- R3: `ready` is high exactly when the single holding register is empty. It is low in the cycle after an accepted write. A write offered while `ready` is low is dropped and never reaches the line.
- R4: The holding register gives up its byte only on the strobe that puts that byte's first bit on the line, and `ready` rises at that strobe. A byte written while idle is therefore released on the 9th strobe after the write, because SYNC occupies the shifter first.
- R5: A packet starts on the first strobe at which the holding register is full in `ST_IDLE`. It begins with SYNC, the byte 0x80 sent LSB first, which gives the line states K J K J K J K K.
- R6: Data bytes follow LSB first, without gaps, in the order written. Each bit is NRZI-encoded: a 0 toggles the line and a 1 holds it. J is `usb_dp`=1/`usb_dm`=0 and K is `usb_dp`=0/`usb_dm`=1.
- R7: After any run of six consecutive 1 bits, counted across byte borders, a 0 bit is inserted. This also happens after the final data bit, just before end-of-packet.
- R8: After the byte written with `wr_last`=1, the line shows SE0 for two bit times and then J for one bit time. After that `usb_oe` falls.
- R9: If the shifter needs a byte mid-packet (the previous byte had no last flag) and the holding register is empty, `underflow` is set and the packet ends with the same SE0, SE0, J sequence. `underflow` stays set until reset.
- R10: `usb_dp`, `usb_dm` and `usb_oe` change only in the cycle after a `bit_tick` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DW (8) | Byte to queue, sent LSB first |
| wr_last | input | 1 | Marks the queued byte as the final byte of the packet |
| ready | output | 1 | Holding register is empty |
| underflow | output | 1 | Sticky: shifter starved mid-packet |
| bit_tick | output | 1 | One-cycle bit-time strobe |
| usb_dp | output | 1 | D+ line level |
| usb_dm | output | 1 | D- line level |
| usb_oe | output | 1 | Line driver enable, high from SYNC through the final J |

## Verification
The assertions assume two things. First, the system clock is more than twice the bit rate, so a strobe never lasts two cycles. Second, the writer offers a byte only while `ready` is high; any other write must be an ignorable one that leaves the held byte untouched. The stimulus runs at 50 MHz, which gives strobes 4 or 5 cycles apart. Every write waits until `ready` is seen high, except one deliberate write into a full holding register, which checks that such a write is dropped. The captured symbol stream is compared with a model built from the byte list, so stuffing, NRZI and the ending are judged only at the pins.

// File: rtl/fs_tx_pkg.sv
package fs_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_DATA,
        ST_SE0_1,
        ST_SE0_2,
        ST_EOP_J
    } tx_state_e;

    // Opening byte of every packet, shifted out LSB first
    localparam logic [7:0] SYNC_BYTE = 8'h80;

    // Length of a run of ones that forces an inserted zero
    localparam int STUFF_RUN = 6;

endpackage

// File: rtl/fs_tx_nco.sv
module fs_tx_nco #(
    parameter int ACC_W  = 16,
    parameter int SYS_HZ = 50_000_000,
    parameter int BIT_HZ = 12_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam longint SCALE = longint'(1) << ACC_W;
    localparam longint INC_L = (2 * longint'(BIT_HZ) * SCALE + longint'(SYS_HZ))
                               / (2 * longint'(SYS_HZ));
    localparam logic [ACC_W-1:0] INC = INC_L[ACC_W-1:0];

    logic [ACC_W-1:0] acc;
    logic [ACC_W:0]   sum;

    assign sum = {1'b0, acc} + {1'b0, INC};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= '0;
            tick <= 1'b0;
        end else begin
            acc  <= sum[ACC_W-1:0];
            tick <= sum[ACC_W];
        end
    end

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2

endmodule

// File: rtl/fs_tx_hold.sv
module fs_tx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_last,
    input  logic          take,
    output logic          ready,
    output logic          q_valid,
    output logic [DW-1:0] q_data,
    output logic          q_last
);
    logic          full;
    logic [DW-1:0] data_r;
    logic          last_r;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full   <= 1'b0;
            data_r <= '0;
            last_r <= 1'b0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_en && !full) begin
            full   <= 1'b1;
            data_r <= wr_data;
            last_r <= wr_last;
        end
    end

    assign ready   = !full;
    assign q_valid = full;
    assign q_data  = data_r;
    assign q_last  = last_r;

    AST_READY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ready) |=> !ready); // R3

    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !take) |=> (!ready && $stable(q_data) && $stable(q_last))); // R3

    AST_TAKE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> q_valid); // R4

endmodule

// File: rtl/fs_tx_serializer.sv
module fs_tx_serializer
    import fs_tx_pkg::*;
#(
    parameter int DW     = 8,
    parameter int ACC_W  = 16,
    parameter int SYS_HZ = 50_000_000,
    parameter int BIT_HZ = 12_000_000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_last,
    output logic          ready,
    output logic          underflow,
    output logic          bit_tick,
    output logic          usb_dp,
    output logic          usb_dm,
    output logic          usb_oe
);
    localparam int CNT_W  = $clog2(DW + 1);
    localparam int ONES_W = $clog2(STUFF_RUN + 1);

    logic          tick;
    logic          take;
    logic          q_valid;
    logic [DW-1:0] q_data;
    logic          q_last;

    fs_tx_nco #(.ACC_W(ACC_W), .SYS_HZ(SYS_HZ), .BIT_HZ(BIT_HZ)) u_nco (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    fs_tx_hold #(.DW(DW)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .wr_last (wr_last),
        .take    (take),
        .ready   (ready),
        .q_valid (q_valid),
        .q_data  (q_data),
        .q_last  (q_last)
    );

    tx_state_e         state, st_n;
    logic [DW-1:0]     shreg, sh_n;
    logic [CNT_W-1:0]  bcnt, cnt_n;
    logic              cur_last, last_n;
    logic [ONES_W-1:0] ones, ones_n, ones_b;
    logic              lvl, lvl_n;   // 1 = J, 0 = K
    logic              uf_r, uf_n;
    logic              emit, ebit;

    // Next-state and datapath decisions, taken only on a bit strobe
    always_comb begin
        st_n   = state;
        sh_n   = shreg;
        cnt_n  = bcnt;
        last_n = cur_last;
        ones_n = ones;
        lvl_n  = lvl;
        uf_n   = uf_r;
        take   = 1'b0;
        emit   = 1'b0;
        ebit   = 1'b0;
        ones_b = ones;
        if (tick) begin
            unique case (state)
                ST_IDLE: begin
                    if (q_valid) begin
                        st_n   = ST_SYNC;
                        emit   = 1'b1;
                        ebit   = SYNC_BYTE[0];
                        sh_n   = DW'(SYNC_BYTE >> 1);
                        cnt_n  = CNT_W'(1);
                        last_n = 1'b0;
                        ones_b = '0;
                    end
                end
                ST_SYNC, ST_DATA: begin
                    if (ones == ONES_W'(STUFF_RUN)) begin
                        lvl_n  = ~lvl;
                        ones_n = '0;
                    end else if (bcnt == CNT_W'(DW)) begin
                        if (cur_last) begin
                            st_n = ST_SE0_1;
                        end else if (q_valid) begin
                            take   = 1'b1;
                            st_n   = ST_DATA;
                            emit   = 1'b1;
                            ebit   = q_data[0];
                            sh_n   = q_data >> 1;
                            cnt_n  = CNT_W'(1);
                            last_n = q_last;
                        end else begin
                            uf_n = 1'b1;
                            st_n = ST_SE0_1;
                        end
                    end else begin
                        emit  = 1'b1;
                        ebit  = shreg[0];
                        sh_n  = shreg >> 1;
                        cnt_n = bcnt + CNT_W'(1);
                    end
                end
                ST_SE0_1: st_n = ST_SE0_2;
                ST_SE0_2: begin
                    st_n  = ST_EOP_J;
                    lvl_n = 1'b1;
                end
                ST_EOP_J: st_n = ST_IDLE;
                default:  st_n = ST_IDLE;
            endcase
            if (emit) begin
                if (ebit) begin
                    ones_n = ones_b + ONES_W'(1);
                end else begin
                    ones_n = '0;
                    lvl_n  = ~lvl;
                end
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            bcnt     <= '0;
            cur_last <= 1'b0;
            ones     <= '0;
            lvl      <= 1'b1;
            uf_r     <= 1'b0;
        end else begin
            state    <= st_n;
            shreg    <= sh_n;
            bcnt     <= cnt_n;
            cur_last <= last_n;
            ones     <= ones_n;
            lvl      <= lvl_n;
            uf_r     <= uf_n;
        end
    end

    // Outputs
    logic se0;
    always_comb begin
        se0       = (state == ST_SE0_1) || (state == ST_SE0_2);
        usb_dp    = !se0 && lvl;
        usb_dm    = !se0 && !lvl;
        usb_oe    = (state != ST_IDLE);
        underflow = uf_r;
        bit_tick  = tick;
    end

    AST_IDLE_J: assert property (@(posedge clk) disable iff (!rst_n)
        !usb_oe |-> (usb_dp && !usb_dm)); // R1

    AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> $stable({usb_dp, usb_dm, usb_oe})); // R10

    AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow); // R9

    AST_NO_LOAD_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> usb_oe); // R4

endmodule

// File: tb/fs_tx_serializer_bench.sv
module fs_tx_serializer_bench;

    localparam longint INC_B = (2 * 64'd12_000_000 * 64'd65536 + 64'd50_000_000)
                               / (2 * 64'd50_000_000);
    localparam int SP_LO = int'(64'd65536 / INC_B);
    localparam int SP_HI = SP_LO + 1;
    localparam int MAXS  = 512;

    // {byte count, bytes packed with byte 0 in bits 7:0}
    localparam logic [34:0] VEC [4] = '{
        {3'd1, 32'h0000_00A5},
        {3'd2, 32'h0000_FFFF},   // long runs of ones, R7
        {3'd3, 32'h00FC_003F},   // ends on six ones: stuffed bit before EOP, R7
        {3'd4, 32'h1881_7EC3}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_last = 1'b0;
    logic       ready, underflow, bit_tick, usb_dp, usb_dm, usb_oe;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    fs_tx_serializer u_fs_tx_serializer (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .wr_last   (wr_last),
        .ready     (ready),
        .underflow (underflow),
        .bit_tick  (bit_tick),
        .usb_dp    (usb_dp),
        .usb_dm    (usb_dm),
        .usb_oe    (usb_oe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Line monitor: one symbol per bit strobe while driven; stability count
    logic [1:0] cap [MAXS];
    int         cap_n = 0;
    int         stab_bad = 0;
    bit         mon_on = 1'b0;
    logic       tick_d = 1'b0;
    logic [2:0] prev_line = 3'b100;

    always @(negedge clk) begin
        if (mon_on) begin
            if (!tick_d && ({usb_dp, usb_dm, usb_oe} != prev_line)) stab_bad++;
            if (tick_d && usb_oe && cap_n < MAXS) begin
                cap[cap_n] = {usb_dp, usb_dm};
                cap_n++;
            end
        end
        prev_line = {usb_dp, usb_dm, usb_oe};
        tick_d    = bit_tick;
    end

    // Expected symbol stream, J=2'b10, K=2'b01, SE0=2'b00
    logic [1:0] exp_s [MAXS];
    int         exp_n;
    logic       e_lvl;
    int         e_ones;

    task automatic e_push(input logic [1:0] s);
        exp_s[exp_n] = s;
        exp_n++;
    endtask

    task automatic e_bit(input logic b);
        if (!b) begin
            e_lvl  = ~e_lvl;
            e_ones = 0;
        end else begin
            e_ones++;
        end
        e_push(e_lvl ? 2'b10 : 2'b01);
        if (e_ones == 6) begin
            e_lvl  = ~e_lvl;
            e_ones = 0;
            e_push(e_lvl ? 2'b10 : 2'b01);
        end
    endtask

    task automatic e_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) e_bit(v[i]);
    endtask

    task automatic e_begin();
        exp_n  = 0;
        e_lvl  = 1'b1;
        e_ones = 0;
        e_byte(8'h80);
    endtask

    task automatic e_end();
        e_push(2'b00);
        e_push(2'b00);
        e_push(2'b10);
    endtask

    task automatic put_byte(input logic [7:0] v, input logic last);
        while (!ready) @(negedge clk);
        wr_en   = 1'b1;
        wr_data = v;
        wr_last = last;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_last = 1'b0;
    endtask

    task automatic wait_pkt_end();
        while (!usb_oe) @(negedge clk);
        while (usb_oe) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic cmp_stream(input string req);
        int bad = -1;
        chk(cap_n == exp_n, req, "symbol count", cap_n, exp_n);
        for (int i = 0; i < exp_n && i < cap_n; i++)
            if (bad < 0 && cap[i] != exp_s[i]) bad = i;
        chk(bad < 0, req, "first mismatching symbol index", bad, -1);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;

        // R1: reset state
        chk(usb_dp == 1'b1 && usb_dm == 1'b0, "R1", "idle J", {usb_dp, usb_dm}, 2);
        chk(usb_oe == 1'b0, "R1", "oe after reset", usb_oe, 0);
        chk(ready == 1'b1, "R1", "ready after reset", ready, 1);
        chk(underflow == 1'b0, "R1", "underflow after reset", underflow, 0);

        // R2: strobe count and spacing over 65536 cycles
        begin
            int ticks = 0;
            int gap = 0;
            int gmin = 1 << 30;
            int gmax = 0;
            bit seen = 0;
            for (int c = 0; c < 65536; c++) begin
                @(negedge clk);
                gap++;
                if (bit_tick) begin
                    ticks++;
                    if (seen) begin
                        if (gap < gmin) gmin = gap;
                        if (gap > gmax) gmax = gap;
                    end
                    seen = 1;
                    gap  = 0;
                end
            end
            chk(ticks == int'(INC_B), "R2", "strobes in 65536 cycles", ticks, int'(INC_B));
            chk(gmin == SP_LO, "R2", "shortest strobe spacing", gmin, SP_LO);
            chk(gmax == SP_HI, "R2", "longest strobe spacing", gmax, SP_HI);
        end

        // R5 R6 R7 R8: table of packets
        foreach (VEC[v]) begin
            int n = int'(VEC[v][34:32]);
            cap_n = 0;
            e_begin();
            for (int k = 0; k < n; k++) e_byte(VEC[v][8*k +: 8]);
            e_end();
            for (int k = 0; k < n; k++) put_byte(VEC[v][8*k +: 8], k == n - 1);
            wait_pkt_end();
            cmp_stream("R5 R6 R7 R8 table");
        end

        // R4: byte written while idle leaves the holding register on strobe 9
        begin
            int nt = 0;
            cap_n = 0;
            e_begin();
            e_byte(8'h5A);
            e_end();
            put_byte(8'h5A, 1'b1);
            chk(ready == 1'b0, "R3", "ready low after write", ready, 0);
            while (!ready) begin
                if (bit_tick) nt++;
                @(negedge clk);
            end
            chk(nt == 9, "R4", "strobes until ready rises", nt, 9);
            wait_pkt_end();
            cmp_stream("R4");
        end

        // R3: write while full is dropped
        cap_n = 0;
        e_begin();
        e_byte(8'h12);
        e_byte(8'h34);
        e_end();
        put_byte(8'h12, 1'b0);
        chk(ready == 1'b0, "R3", "ready low with byte held", ready, 0);
        wr_en   = 1'b1;
        wr_data = 8'h55;
        wr_last = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_last = 1'b0;
        put_byte(8'h34, 1'b1);
        wait_pkt_end();
        cmp_stream("R3 ignored write");

        // R9: starved shifter ends the packet and sets a sticky flag
        cap_n = 0;
        e_begin();
        e_byte(8'h0F);
        e_end();
        put_byte(8'h0F, 1'b0);
        wait_pkt_end();
        cmp_stream("R9 cut-short packet");
        chk(underflow == 1'b1, "R9", "underflow set", underflow, 1);
        chk(usb_dp == 1'b1 && usb_dm == 1'b0 && usb_oe == 1'b0, "R1",
            "idle J after cut-short packet", {usb_dp, usb_dm, usb_oe}, 4);

        cap_n = 0;
        e_begin();
        e_byte(8'hC3);
        e_end();
        put_byte(8'hC3, 1'b1);
        wait_pkt_end();
        cmp_stream("R8 packet after underflow");
        chk(underflow == 1'b1, "R9", "underflow still set", underflow, 1);

        // R10: line only moves after a strobe
        chk(stab_bad == 0, "R10", "line changes without strobe", stab_bad, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule